// File: doc/BRIEF.md
# Successive-Approximation ADC Conversion Sequencer

This block is the digital control for a successive-approximation converter. It makes a conversion-clock enable from a selectable source divided by a programmable ratio. It then runs each conversion through synchronisation, warm-up, sampling and bit-decision phases. The DAC trial code is driven out and the comparator answer is read back once per conversion-clock period. The final code is stored in a result register. The comparator, DAC and references sit outside the block.

A conversion starts on a one-cycle `start_i` pulse. The resolution, sample length, continuous flag, source and divide ratio are captured on that same edge. In single mode the block returns to idle after one result. In continuous mode it re-enters sampling straight away and skips both the synchronisation overhead and the warm-up. `abort_i` halts the sequencer without a clock edge and keeps the last result. Reset also clears the result.

Top module: `sar_adc_ctrl`

## Requirements
- R1: With the bus clock as source and divide code 0, a single conversion or the first conversion in continuous mode raises `done_o` exactly 3 + N bus edges after the edge that samples `start_i`. N is 18 for 8-bit short, 38 for 8-bit long, 21 for 10-bit short and 41 for 10-bit long (`wide_i`=1 selects 10-bit, `long_smp_i`=1 selects long sampling).
- R2: In continuous mode (`cont_i`=1), every conversion after the first completes N−2 conversion-clock periods after the previous one: 16, 36, 19 or 39.
- R3: `div_sel_i` codes 0, 1, 2 and 3 divide the source by 1, 2, 4 and 8, so a conversion-clock period is that many source ticks. With `alt_sel_i`=0 the source ticks on every bus edge. With `alt_sel_i`=1 it ticks only on bus edges where `alt_tick_i` is high.
- R4: Bits are decided MSB first, one per conversion-clock period. A trial bit is kept when `cmp_i`=1, meaning the input is at or above `trial_o`. The result is therefore the input code clipped to full scale. `trial_o` is zero whenever the block is idle.
- R5: An 8-bit result sits in `result_o[7:0]`, and `result_o[9:8]` read as zero.
- R6: `result_o` and `done_o` update on the same edge. `done_o` clears on the edge after `rd_i`=1, or after a `start_i` that is not blocked by abort.
- R7: `abort_i`=1 drops `ref_en_o` at once, with no clock edge. The result register and `done_o` keep their values, and `start_i` is ignored while abort is held.
- R8: An active-low `rst_ni` immediately forces `result_o` to 0, `done_o` to 0 and `ref_en_o` to 0.
- R9: `ref_en_o` is high from the edge that samples `start_i` until a single conversion completes. It stays high for the whole run in continuous mode.
- R10: Changing the mode, source or divide inputs during a conversion has no effect on its timing, its resolution or whether it continues.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| alt_tick_i | input | 1 | Alternate source tick, sampled on the bus clock |
| alt_sel_i | input | 1 | 1 selects the alternate source |
| div_sel_i | input | 2 | Source divide code |
| start_i | input | 1 | Conversion start pulse |
| cont_i | input | 1 | Continuous mode |
| wide_i | input | 1 | 1 = 10-bit, 0 = 8-bit |
| long_smp_i | input | 1 | Long sampling |
| abort_i | input | 1 | Asynchronous abort, active high |
| rd_i | input | 1 | Result read strobe, clears done |
| cmp_i | input | 1 | Comparator: input at or above trial code |
| trial_o | output | 10 | DAC trial code |
| ref_en_o | output | 1 | Reference and analog enable |
| result_o | output | 10 | Conversion result |
| done_o | output | 1 | Result valid |

## Verification
A phase or counter that is off by one shifts the edge where `done_o` rises. The per-edge reference model catches this on the very edge where the result should have landed, and each mode combination is exercised for it. A wrong trial bit or a wrong bit order gives a wrong code on that same edge, because the comparator in the bench answers from the live trial code. A stuck abort path or reset path shows on `ref_en_o` within half a bus period, or on `result_o` on the first edge after release.

// File: rtl/sar_pkg.sv
package sar_pkg;
  localparam int unsigned DIV_W = 2;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_SYNC,
    PH_WARM,
    PH_SMP,
    PH_BITS
  } phase_e;

  typedef struct packed {
    logic             alt;
    logic [DIV_W-1:0] div;
    logic             cont;
    logic             wide;
    logic             lng;
  } cfg_t;
endpackage

// File: rtl/sar_clk_div.sv
module sar_clk_div
  import sar_pkg::*;
#(
  parameter int unsigned DW = DIV_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          abort_i,
  input  logic          run_i,
  input  logic          alt_sel_i,
  input  logic          alt_tick_i,
  input  logic [DW-1:0] div_sel_i,
  output logic          adck_en_o
);
  localparam int unsigned CW = (1 << DW) - 1;

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] lim;
  logic          src_tick;

  assign lim       = CW'((32'd1 << div_sel_i) - 32'd1);
  assign src_tick  = alt_sel_i ? alt_tick_i : 1'b1;
  assign adck_en_o = run_i & src_tick & (cnt_q == lim) & ~abort_i;

  always_ff @(posedge clk_i or negedge rst_ni or posedge abort_i) begin
    if (!rst_ni || abort_i)  cnt_q <= '0;
    else if (!run_i)         cnt_q <= '0;
    else if (src_tick)       cnt_q <= (cnt_q == lim) ? '0 : cnt_q + 1'b1;
  end
endmodule

// File: rtl/sar_seq.sv
module sar_seq
  import sar_pkg::*;
#(
  parameter int unsigned RES_W      = 10,
  parameter int unsigned SYNC_CYC   = 3,
  parameter int unsigned WARM_CYC   = 2,
  parameter int unsigned SMP_BASE   = 8,
  parameter int unsigned LONG_EXTRA = 20,
  parameter int unsigned CNT_W      = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             abort_i,
  input  logic             start_i,
  input  logic             adck_en_i,
  input  cfg_t             cfg_i,
  output cfg_t             cfg_o,
  output phase_e           phase_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             run_o,
  output logic             final_o
);
  phase_e           phase_q;
  logic [CNT_W-1:0] cnt_q;
  cfg_t             cfg_q;
  logic [CNT_W-1:0] smp_ld;
  logic [CNT_W-1:0] bits_ld;
  logic             cnt_zero;

  // mode capture survives abort so the held result keeps its meaning
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  cfg_q <= '0;
    else if (start_i && !abort_i) cfg_q <= cfg_i;
  end

  assign smp_ld  = CNT_W'(SMP_BASE - 1)
                 + (cfg_q.wide ? CNT_W'(1) : '0)
                 + (cfg_q.lng  ? CNT_W'(LONG_EXTRA) : '0);
  assign bits_ld = cfg_q.wide ? CNT_W'(RES_W - 1) : CNT_W'(RES_W - 3);
  assign cnt_zero = (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni or posedge abort_i) begin
    if (!rst_ni || abort_i) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
    end else if (start_i) begin
      phase_q <= PH_SYNC;
      cnt_q   <= CNT_W'(SYNC_CYC - 1);
    end else begin
      unique case (phase_q)
        PH_SYNC: begin
          if (cnt_zero) begin
            phase_q <= PH_WARM;
            cnt_q   <= CNT_W'(WARM_CYC - 1);
          end else cnt_q <= cnt_q - 1'b1;
        end
        PH_WARM: if (adck_en_i) begin
          if (cnt_zero) begin
            phase_q <= PH_SMP;
            cnt_q   <= smp_ld;
          end else cnt_q <= cnt_q - 1'b1;
        end
        PH_SMP: if (adck_en_i) begin
          if (cnt_zero) begin
            phase_q <= PH_BITS;
            cnt_q   <= bits_ld;
          end else cnt_q <= cnt_q - 1'b1;
        end
        PH_BITS: if (adck_en_i) begin
          if (cnt_zero) begin
            phase_q <= cfg_q.cont ? PH_SMP : PH_IDLE;
            cnt_q   <= cfg_q.cont ? smp_ld : '0;
          end else cnt_q <= cnt_q - 1'b1;
        end
        default: ;
      endcase
    end
  end

  assign cfg_o   = cfg_q;
  assign phase_o = phase_q;
  assign cnt_o   = cnt_q;
  assign run_o   = (phase_q == PH_WARM) || (phase_q == PH_SMP) || (phase_q == PH_BITS);
  assign final_o = (phase_q == PH_BITS) && adck_en_i && cnt_zero && !start_i;
endmodule

// File: rtl/sar_reg.sv
module sar_reg #(
  parameter int unsigned RES_W = 10,
  parameter int unsigned CNT_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             abort_i,
  input  logic             start_i,
  input  logic             rd_i,
  input  logic             cmp_i,
  input  logic             in_bits_i,
  input  logic             adck_en_i,
  input  logic             final_i,
  input  logic [CNT_W-1:0] bit_idx_i,
  output logic [RES_W-1:0] trial_o,
  output logic [RES_W-1:0] result_o,
  output logic             done_o
);
  logic [RES_W-1:0] sar_q;
  logic [RES_W-1:0] bit_mask;
  logic [RES_W-1:0] sar_d;
  logic [RES_W-1:0] result_q;
  logic             done_q;

  assign bit_mask = RES_W'(1) << bit_idx_i;
  assign sar_d    = sar_q | (cmp_i ? bit_mask : '0);
  assign trial_o  = in_bits_i ? (sar_q | bit_mask) : '0;

  always_ff @(posedge clk_i or negedge rst_ni or posedge abort_i) begin
    if (!rst_ni || abort_i)      sar_q <= '0;
    else if (!in_bits_i)         sar_q <= '0;
    else if (adck_en_i)          sar_q <= sar_d;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      result_q <= '0;
      done_q   <= 1'b0;
    end else if (final_i) begin
      result_q <= sar_d;
      done_q   <= 1'b1;
    end else if ((start_i && !abort_i) || rd_i) begin
      done_q   <= 1'b0;
    end
  end

  assign result_o = result_q;
  assign done_o   = done_q;
endmodule

// File: rtl/sar_adc_ctrl.sv
module sar_adc_ctrl
  import sar_pkg::*;
#(
  parameter int unsigned RES_W      = 10,
  parameter int unsigned SYNC_CYC   = 3,
  parameter int unsigned WARM_CYC   = 2,
  parameter int unsigned SMP_BASE   = 8,
  parameter int unsigned LONG_EXTRA = 20
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             alt_tick_i,
  input  logic             alt_sel_i,
  input  logic [DIV_W-1:0] div_sel_i,
  input  logic             start_i,
  input  logic             cont_i,
  input  logic             wide_i,
  input  logic             long_smp_i,
  input  logic             abort_i,
  input  logic             rd_i,
  input  logic             cmp_i,
  output logic [RES_W-1:0] trial_o,
  output logic             ref_en_o,
  output logic [RES_W-1:0] result_o,
  output logic             done_o
);
  localparam int unsigned CNT_MAX = SMP_BASE + 1 + LONG_EXTRA + RES_W + SYNC_CYC + WARM_CYC;
  localparam int unsigned CNT_W   = $clog2(CNT_MAX + 1);

  cfg_t             cfg_in;
  cfg_t             cfg_q;
  phase_e           phase;
  logic [CNT_W-1:0] cnt;
  logic             run;
  logic             fin;
  logic             adck_en;
  logic             wide_q;

  assign cfg_in = '{alt: alt_sel_i, div: div_sel_i, cont: cont_i, wide: wide_i, lng: long_smp_i};
  assign wide_q = cfg_q.wide;

  sar_clk_div #(.DW(DIV_W)) i_div (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .abort_i    (abort_i),
    .run_i      (run),
    .alt_sel_i  (cfg_q.alt),
    .alt_tick_i (alt_tick_i),
    .div_sel_i  (cfg_q.div),
    .adck_en_o  (adck_en)
  );

  sar_seq #(
    .RES_W(RES_W), .SYNC_CYC(SYNC_CYC), .WARM_CYC(WARM_CYC),
    .SMP_BASE(SMP_BASE), .LONG_EXTRA(LONG_EXTRA), .CNT_W(CNT_W)
  ) i_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .abort_i   (abort_i),
    .start_i   (start_i),
    .adck_en_i (adck_en),
    .cfg_i     (cfg_in),
    .cfg_o     (cfg_q),
    .phase_o   (phase),
    .cnt_o     (cnt),
    .run_o     (run),
    .final_o   (fin)
  );

  sar_reg #(.RES_W(RES_W), .CNT_W(CNT_W)) i_reg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .abort_i   (abort_i),
    .start_i   (start_i),
    .rd_i      (rd_i),
    .cmp_i     (cmp_i),
    .in_bits_i (phase == PH_BITS),
    .adck_en_i (adck_en),
    .final_i   (fin),
    .bit_idx_i (cnt),
    .trial_o   (trial_o),
    .result_o  (result_o),
    .done_o    (done_o)
  );

  assign ref_en_o = (phase != PH_IDLE);
endmodule

// File: rtl/sar_adc_ctrl_chk.sv
module sar_adc_ctrl_chk #(
  parameter int unsigned RES_W = 10
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic             abort_i,
  input logic             ref_en_o,
  input logic             done_o,
  input logic             wide_q,
  input logic [RES_W-1:0] result_o,
  input logic [RES_W-1:0] trial_o
);
  AST_RESULT_WITH_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (result_o != $past(result_o)) |-> done_o); // R6

  AST_START_CLEARS_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !abort_i) |=> !done_o); // R6

  AST_NARROW_UPPER_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !wide_q) |-> (result_o[RES_W-1 -: 2] == 2'b00)); // R5

  AST_ABORT_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_i |-> !ref_en_o); // R7

  AST_IDLE_TRIAL_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ref_en_o |-> (trial_o == '0)); // R4

  AST_START_POWERS_UP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !abort_i) |=> (ref_en_o || abort_i)); // R9
endmodule

bind sar_adc_ctrl sar_adc_ctrl_chk #(.RES_W(RES_W)) i_sar_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .start_i  (start_i),
  .abort_i  (abort_i),
  .ref_en_o (ref_en_o),
  .done_o   (done_o),
  .wide_q   (wide_q),
  .result_o (result_o),
  .trial_o  (trial_o)
);

// File: tb/test_sar_adc_ctrl.sv
`timescale 1ns/100ps
module test_sar_adc_ctrl;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       alt_tick_i = 1'b0;
  logic       alt_sel_i = 1'b0;
  logic [1:0] div_sel_i = 2'd0;
  logic       start_i = 1'b0;
  logic       cont_i = 1'b0;
  logic       wide_i = 1'b0;
  logic       long_smp_i = 1'b0;
  logic       abort_i = 1'b0;
  logic       rd_i = 1'b0;
  logic       cmp_i;
  logic [9:0] trial_o;
  logic       ref_en_o;
  logic [9:0] result_o;
  logic       done_o;

  int    vin = 0;
  int    checks = 0;
  int    errors = 0;
  bit    ended = 1'b0;
  string cur_req = "R1";

  always #2.5 clk_i = ~clk_i;

  assign cmp_i = (vin >= int'(trial_o));

  sar_adc_ctrl i_sar_adc_ctrl (.*);

  int a_cnt = 0;
  always @(negedge clk_i) begin
    a_cnt++;
    alt_tick_i <= (a_cnt % 3 == 0);
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference: phase, divider and tick counts as integers
  int m_mode = 0, m_sync = 0, m_dcnt = 0, m_adck = 0, m_need = 0;
  int m_res = 0, m_done = 0, m_d = 1, m_alt = 0, m_cont = 0, m_wide = 0, m_base = 0;

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      m_mode = 0; m_res = 0; m_done = 0;
    end else if (abort_i) begin
      m_mode = 0;
    end else if (start_i) begin
      m_d = 1 << div_sel_i; m_alt = alt_sel_i; m_cont = cont_i; m_wide = wide_i;
      m_base = (wide_i ? 21 : 18) + (long_smp_i ? 20 : 0);
      m_need = m_base; m_mode = 1; m_sync = 3; m_dcnt = 0; m_adck = 0; m_done = 0;
    end else begin
      if (rd_i) m_done = 0;
      if (m_mode == 1) begin
        m_sync--;
        if (m_sync == 0) m_mode = 2;
      end else if (m_mode == 2 && (!m_alt || alt_tick_i)) begin
        m_dcnt++;
        if (m_dcnt == m_d) begin
          m_dcnt = 0;
          m_adck++;
          if (m_adck == m_need) begin
            m_res  = (vin > (m_wide ? 1023 : 255)) ? (m_wide ? 1023 : 255) : vin;
            m_done = 1;
            m_adck = 0;
            if (m_cont) m_need = m_base - 2;
            else m_mode = 0;
          end
        end
      end
    end
  end

  always @(posedge clk_i) begin
    #1;
    chk({cur_req, " done timing"}, int'(done_o), m_done);
    chk({cur_req, " result"}, int'(result_o), m_res);
    chk("R9 ref_en", int'(ref_en_o), (m_mode != 0) ? 1 : 0);
  end

  task automatic conv(input int dsel, input int alt, input int cont, input int wide,
                      input int lng, input int v, input bit scramble, output int lat);
    @(negedge clk_i);
    div_sel_i = 2'(dsel); alt_sel_i = alt[0]; cont_i = cont[0];
    wide_i = wide[0]; long_smp_i = lng[0]; vin = v; start_i = 1'b1;
    @(posedge clk_i);
    @(negedge clk_i);
    start_i = 1'b0;
    if (scramble) begin
      div_sel_i = 2'd3; alt_sel_i = 1'b1; cont_i = 1'b1; wide_i = 1'b1; long_smp_i = 1'b1;
    end
    lat = 0;
    while (lat < 5000) begin
      @(posedge clk_i); #1; lat++;
      if (done_o) break;
    end
  endtask

  task automatic next_conv(input int v, output int lat);
    @(negedge clk_i);
    rd_i = 1'b1; vin = v;
    lat = 0;
    while (lat < 5000) begin
      @(posedge clk_i); #1; lat++;
      if (done_o) break;
      @(negedge clk_i);
      rd_i = 1'b0;
    end
    rd_i = 1'b0;
  endtask

  initial begin
    #(5.0 * 150000);
    checks++; errors++;
    $display("FAIL watchdog expired");
    if (!ended) begin
      ended = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
    end
    $finish;
  end

  initial begin
    int lat;
    repeat (3) @(negedge clk_i);
    chk("R8 reset result", int'(result_o), 0);
    chk("R8 reset done", int'(done_o), 0);
    chk("R8 reset ref_en", int'(ref_en_o), 0);
    rst_ni = 1'b1;

    cur_req = "R1";
    conv(0, 0, 0, 0, 0, 165, 1'b0, lat);
    chk("R1 8b short latency", lat, 21);
    chk("R4 8b code", int'(result_o), 165);
    chk("R9 idle after single", int'(ref_en_o), 0);

    cur_req = "R3";
    conv(1, 0, 0, 1, 0, 707, 1'b0, lat);
    chk("R3 div2 10b short latency", lat, 45);
    chk("R4 10b code", int'(result_o), 707);

    cur_req = "R5";
    conv(0, 0, 0, 0, 1, 1000, 1'b0, lat);
    chk("R1 8b long latency", lat, 41);
    chk("R5 8b clipped", int'(result_o), 255);
    chk("R5 upper bits zero", int'(result_o[9:8]), 0);

    cur_req = "R3";
    conv(3, 0, 0, 1, 1, 0, 1'b0, lat);
    chk("R3 div8 10b long latency", lat, 331);
    chk("R4 zero code", int'(result_o), 0);
    conv(2, 0, 0, 0, 0, 1, 1'b0, lat);
    chk("R3 div4 latency", lat, 75);

    cur_req = "R6";
    @(negedge clk_i); rd_i = 1'b1;
    @(posedge clk_i); #1;
    chk("R6 read clears done", int'(done_o), 0);
    chk("R6 read keeps result", int'(result_o), 1);
    @(negedge clk_i); rd_i = 1'b0;

    cur_req = "R10";
    conv(0, 0, 0, 0, 0, 90, 1'b1, lat);
    chk("R10 latched mode latency", lat, 21);
    chk("R10 latched resolution", int'(result_o), 90);
    chk("R10 latched single mode", int'(ref_en_o), 0);

    cur_req = "R2";
    conv(0, 0, 1, 1, 0, 512, 1'b0, lat);
    chk("R1 10b short first", lat, 24);
    chk("R4 first cont code", int'(result_o), 512);
    next_conv(300, lat);
    chk("R2 10b short next", lat, 19);
    chk("R4 second cont code", int'(result_o), 300);
    next_conv(77, lat);
    chk("R2 10b short third", lat, 19);

    cur_req = "R7";
    repeat (5) @(negedge clk_i);
    abort_i = 1'b1; vin = 500;
    #0.5;
    chk("R7 abort drops ref_en at once", int'(ref_en_o), 0);
    @(negedge clk_i); abort_i = 1'b0;
    repeat (3) @(posedge clk_i);
    #1;
    chk("R7 abort keeps result", int'(result_o), 77);
    chk("R7 abort keeps done", int'(done_o), 1);
    chk("R7 abort stays idle", int'(ref_en_o), 0);

    @(negedge clk_i); abort_i = 1'b1; start_i = 1'b1;
    @(negedge clk_i); abort_i = 1'b0; start_i = 1'b0;
    #1;
    chk("R7 start ignored in abort", int'(ref_en_o), 0);

    cur_req = "R2";
    conv(0, 0, 1, 0, 0, 200, 1'b0, lat);
    chk("R1 8b short first cont", lat, 21);
    next_conv(17, lat);
    chk("R2 8b short next", lat, 16);
    chk("R4 8b cont code", int'(result_o), 17);

    cur_req = "R6";
    @(negedge clk_i); cont_i = 1'b0; start_i = 1'b1;
    @(posedge clk_i); #1;
    chk("R6 start clears done", int'(done_o), 0);
    @(negedge clk_i); start_i = 1'b0;
    repeat (30) @(negedge clk_i);

    cur_req = "R3";
    conv(1, 1, 0, 0, 0, 33, 1'b0, lat);
    chk("R3 alternate source code", int'(result_o), 33);
    chk("R3 alternate source slower", (lat > 90) ? 1 : 0, 1);

    cur_req = "R8";
    @(negedge clk_i); vin = 10; start_i = 1'b1;
    @(negedge clk_i); start_i = 1'b0;
    repeat (6) @(negedge clk_i);
    rst_ni = 1'b0;
    #0.5;
    chk("R8 reset clears result", int'(result_o), 0);
    chk("R8 reset drops ref_en", int'(ref_en_o), 0);
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk_i);
    chk("R8 result after reset", int'(result_o), 0);

    ended = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule